// File: doc/BRIEF.md
# Sticky Supervisory Status Register

This block gathers eight fault indications into one supervisory status word and raises an interrupt request. Four of the fault inputs are undervoltage flags for the external supplies. Two are undervoltage flags for internally generated rails. One flags chip overtemperature, and one flags a CRC mismatch in configuration or calibration data. Each input may arrive as a single-cycle pulse or as a level. A fault latches its status bit, and the bit stays set after the condition goes away.

Software reads the status word through a small register port that has a read strobe and an address. The same read that returns the word also clears every enabled bit. A per-bit enable register masks bits from both the read data and the interrupt. A masked bit keeps its latched value through reads, so it shows up once it is enabled again. A configuration bit declares that one supply is strapped to a lower rail. While that bit is set, the undervoltage flag of that supply is ignored.

Top module: `supv_status`

## Requirements
- R1: After reset the status word is 0, the enable register is all ones, the configuration register is 0, and `irq` is 0.
- R2: When `errIn[i]` is high at a rising clock edge, status bit i is set. It stays set after the input returns low, until a clearing read. Bit positions: 0 to 3 are the external supply undervoltage flags, 4 and 5 are the internal rail undervoltage flags, 6 is overtemperature, and 7 is the CRC error.
- R3: A read with `addr` 0 returns status AND enable on `rdData` in the same cycle. At the end of that cycle it clears every status bit whose enable is 1.
- R4: When a fault input is high in the same cycle as a clearing read, its bit is still set after that read.
- R5: A clearing read does not change status bits whose enable is 0. After such a bit is enabled, the next status read reports it.
- R6: `irq` is combinational and is 1 exactly when some status bit and its enable are both 1. A write to the enable register changes `irq` from the following cycle.
- R7: A write with `addr` 1 loads the enable register. A read with `addr` 1 returns it.
- R8: A write with `addr` 2 loads bit 0 of `wrData` into the strap configuration bit, and a read with `addr` 2 returns it in bit 0 with zeros above. While the strap bit is 1, `errIn[TIED_IDX]` (default bit 0) never sets its status bit. The other inputs still work.
- R9: A write to `addr` 0 and a read of any address other than 0 leave the status word unchanged. A read of `addr` 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| errIn | input | NUM_ERR | Fault indications, one per status bit |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | NUM_ERR | Write data |
| rdData | output | NUM_ERR | Combinational read data |
| irq | output | 1 | Interrupt request |

## Verification
A status bit lost in error shows up on the very next status read as a missing one, and `irq` drops at once. A bit stuck at one, or a clear that wrongly reaches a masked bit, shows up on the read that follows. The bench shows this by re-enabling the mask and reading the word again. A wrong priority between a set and a clear only shows when a fault is held high across a read. The bench therefore holds a fault through a read and then reads twice more.

// File: rtl/supv_status_pkg.sv
package supv_status_pkg;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_CONFIG = 2;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_CONFIG = 2'd2,
    SEL_NONE   = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   clrStatus;
    logic   wrEnable;
    logic   wrConfig;
    rdSel_e rdSel;
  } supvStrobe_t;
endpackage

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_status_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output supvStrobe_t       strobe
);
  logic isStatus, isEnable, isConfig;

  assign isStatus = (addr == ADDR_W'(ADDR_STATUS));
  assign isEnable = (addr == ADDR_W'(ADDR_ENABLE));
  assign isConfig = (addr == ADDR_W'(ADDR_CONFIG));

  always_comb begin
    strobe.clrStatus = rdEn && isStatus;
    strobe.wrEnable  = wrEn && isEnable;
    strobe.wrConfig  = wrEn && isConfig;
    if (isStatus)      strobe.rdSel = SEL_STATUS;
    else if (isEnable) strobe.rdSel = SEL_ENABLE;
    else if (isConfig) strobe.rdSel = SEL_CONFIG;
    else               strobe.rdSel = SEL_NONE;
  end
endmodule

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_status_pkg::*;
#(
  parameter int NUM_ERR  = 8,
  parameter int TIED_IDX = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_ERR-1:0] errIn,
  input  logic [NUM_ERR-1:0] wrData,
  input  supvStrobe_t        strobe,
  output logic [NUM_ERR-1:0] rdData,
  output logic               irq,
  output logic [NUM_ERR-1:0] statusVec,
  output logic [NUM_ERR-1:0] enableVec,
  output logic               cfgTied
);
  logic [NUM_ERR-1:0] setVec;
  logic [NUM_ERR-1:0] clrVec;
  logic [NUM_ERR-1:0] visible;

  generate
    for (genvar i = 0; i < NUM_ERR; i++) begin : g_bit
      if (i == TIED_IDX) begin : g_tied
        assign setVec[i] = errIn[i] && !cfgTied;
      end else begin : g_plain
        assign setVec[i] = errIn[i];
      end
      assign clrVec[i] = strobe.clrStatus && enableVec[i];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          statusVec[i] <= 1'b0;
        else if (setVec[i]) statusVec[i] <= 1'b1;
        else if (clrVec[i]) statusVec[i] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableVec <= '1;
      cfgTied   <= 1'b0;
    end else begin
      if (strobe.wrEnable) enableVec <= wrData;
      if (strobe.wrConfig) cfgTied   <= wrData[0];
    end
  end

  assign visible = statusVec & enableVec;
  assign irq     = |visible;

  always_comb begin
    case (strobe.rdSel)
      SEL_STATUS: rdData = visible;
      SEL_ENABLE: rdData = enableVec;
      SEL_CONFIG: rdData = NUM_ERR'(cfgTied);
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/supv_status.sv
module supv_status
  import supv_status_pkg::*;
#(
  parameter int NUM_ERR  = 8,
  parameter int ADDR_W   = 2,
  parameter int TIED_IDX = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_ERR-1:0] errIn,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_ERR-1:0] wrData,
  output logic [NUM_ERR-1:0] rdData,
  output logic               irq
);
  supvStrobe_t        strobe;
  logic [NUM_ERR-1:0] statusVec;
  logic [NUM_ERR-1:0] enableVec;
  logic               cfgTied;

  supv_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strobe(strobe)
  );

  supv_datapath #(.NUM_ERR(NUM_ERR), .TIED_IDX(TIED_IDX)) u_dp (
    .clk(clk), .rstN(rstN), .errIn(errIn), .wrData(wrData),
    .strobe(strobe), .rdData(rdData), .irq(irq),
    .statusVec(statusVec), .enableVec(enableVec), .cfgTied(cfgTied)
  );
endmodule

// File: rtl/supv_status_chk.sv
module supv_status_chk #(
  parameter int NUM_ERR  = 8,
  parameter int ADDR_W   = 2,
  parameter int TIED_IDX = 0
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_ERR-1:0] errIn,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic               irq,
  input logic [NUM_ERR-1:0] statusVec,
  input logic [NUM_ERR-1:0] enableVec,
  input logic               cfgTied
);
  logic clearing;
  assign clearing = rdEn && (addr == '0);

  generate
    for (genvar i = 0; i < NUM_ERR; i++) begin : g_chk
      // R2, R4: an accepted fault is latched at the next edge, even during a clear
      a_r2_fault_latches: assert property (@(posedge clk) disable iff (!rstN)
        (errIn[i] && !(i == TIED_IDX && cfgTied)) |=> statusVec[i]);
      // R3, R9: a set bit survives unless an enabled clearing read hits it
      a_r3_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
        (statusVec[i] && !(clearing && enableVec[i])) |=> statusVec[i]);
      // R5: masked bits keep their value through a clearing read
      a_r5_masked_kept: assert property (@(posedge clk) disable iff (!rstN)
        (clearing && !enableVec[i] && statusVec[i]) |=> statusVec[i]);
    end
  endgenerate

  // R6: no latched fault means no interrupt
  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec == '0) |-> !irq);

  // R8: strapped supply cannot newly set its bit
  a_r8_tied_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfgTied && !statusVec[TIED_IDX]) |=> !statusVec[TIED_IDX]);
endmodule

bind supv_status supv_status_chk #(
  .NUM_ERR(NUM_ERR), .ADDR_W(ADDR_W), .TIED_IDX(TIED_IDX)
) u_chk (
  .clk(clk), .rstN(rstN), .errIn(errIn), .rdEn(rdEn), .addr(addr),
  .irq(irq), .statusVec(statusVec), .enableVec(enableVec), .cfgTied(cfgTied)
);

// File: tb/supv_status_tb.sv
module supv_status_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] errIn = '0;
  logic         wrEn = 1'b0;
  logic         rdEn = 1'b0;
  logic [1:0]   addr = '0;
  logic [N-1:0] wrData = '0;
  logic [N-1:0] rdData;
  logic         irq;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  supv_status u_dut (
    .clk(clk), .rstN(rstN), .errIn(errIn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseErr(input logic [N-1:0] v);
    @(negedge clk);
    errIn = v;
    @(negedge clk);
    errIn = '0;
  endtask

  initial begin
    logic [N-1:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    #1 chk("R1 irq", {7'b0, irq}, 8'h00);
    regRead(2'd1, d); chk("R1 enable", d, 8'hFF);
    regRead(2'd2, d); chk("R1 config", d, 8'h00);
    regRead(2'd0, d); chk("R1 status", d, 8'h00);

    // R2, R3, R6: each source alone latches, reads, then clears
    for (int i = 0; i < N; i++) begin
      pulseErr(N'(1) << i);
      #1 chk("R6 irq set", {7'b0, irq}, 8'h01);
      regRead(2'd0, d); chk("R2 sticky bit", d, N'(1) << i);
      #1 chk("R3 irq after clear", {7'b0, irq}, 8'h00);
      regRead(2'd0, d); chk("R3 cleared", d, 8'h00);
    end

    // R5, R7: exhaustive enable masks
    for (int m = 0; m < 256; m++) begin
      regWrite(2'd1, N'(m));
      regRead(2'd1, d); chk("R7 enable readback", d, N'(m));
      pulseErr(8'hFF);
      #1 chk("R6 irq masked", {7'b0, irq}, {7'b0, (m != 0)});
      regRead(2'd0, d); chk("R5 masked read", d, N'(m));
      regWrite(2'd1, 8'hFF);
      regRead(2'd0, d); chk("R5 revealed", d, ~N'(m));
      regRead(2'd0, d); chk("R5 empty", d, 8'h00);
    end

    // R6: enabling a masked latched bit raises irq the next cycle
    regWrite(2'd1, 8'h00);
    pulseErr(8'h40);
    #1 chk("R6 irq off when masked", {7'b0, irq}, 8'h00);
    regWrite(2'd1, 8'h40);
    #1 chk("R6 irq after enable", {7'b0, irq}, 8'h01);
    regWrite(2'd1, 8'hFF);
    regRead(2'd0, d);

    // R4: fault held through a clearing read
    @(negedge clk); errIn = 8'h04;
    @(negedge clk);
    rdEn = 1'b1; addr = 2'd0;
    #1 chk("R4 read during set", rdData, 8'h04);
    @(negedge clk); rdEn = 1'b0; errIn = '0;
    regRead(2'd0, d); chk("R4 set wins", d, 8'h04);
    regRead(2'd0, d); chk("R4 then clears", d, 8'h00);

    // R8: strap suppresses bit 0 only
    regWrite(2'd2, 8'hFF);
    regRead(2'd2, d); chk("R8 config readback", d, 8'h01);
    pulseErr(8'h03);
    regRead(2'd0, d); chk("R8 strapped ignored", d, 8'h02);
    regWrite(2'd2, 8'h00);
    pulseErr(8'h01);
    regRead(2'd0, d); chk("R8 unstrapped sets", d, 8'h01);

    // R9: writes to status and reads elsewhere do not clear
    pulseErr(8'h10);
    regWrite(2'd0, 8'hFF);
    regRead(2'd1, d); chk("R9 enable read", d, 8'hFF);
    regRead(2'd3, d); chk("R9 addr3 zero", d, 8'h00);
    regRead(2'd0, d); chk("R9 status kept", d, 8'h10);

    finished = 1'b1;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
  end

  initial begin
    wait (finished || checks < 0);
    #1;
  end

  always @(posedge clk) begin
    if (finished || (fails > 0 && !finished && $time > 150000 * 8)) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule